// File: doc/BRIEF.md
# Linked-List DMA Read Engine

This block copies data from a remote, slave-only bus space into local memory without processor help. Software places a chain of transfer descriptors in local memory and presents the address of the first one. It then pulses a start input. The engine reads each descriptor from local memory and performs the transfer that descriptor asks for. Each word is one ordinary remote read cycle followed by one local write. The engine then follows the descriptor's link, and it stops after a descriptor whose final flag is set.

The whole chain runs as a single transaction. At the end the engine either sets a completion flag or, if a remote cycle is never acknowledged, gives up on the rest of the chain. In the second case it records which descriptor failed. An interrupt line reflects either outcome when it is enabled. The remote bus and the local memory are both modelled as simple request/acknowledge master ports, and there is at most one outstanding request on them at any time.

Top module: `chain_dma_master`

## Requirements
- R1: After reset, busy, done, err and irq are low, and neither bus_req nor mem_req is asserted.
- R2: A go pulse while idle is accepted on that clock edge. In the next cycle busy is high and a local read of the head address is requested.
- R3: A descriptor is four 32-bit words at rising byte addresses, 4 apart: word 0 is the remote source address, word 1 is the local destination address, word 2 is control, word 3 is the link to the next descriptor. In the control word, bit 31 is the final flag, bits 29:24 are the cycle-type code and bits 23:0 are the byte count.
- R4: Each word moves as one remote read at the current source address with the descriptor's cycle-type code on bus_am, then one local write of the data read to the current destination. Both addresses then advance by 4.
- R5: The word count is the byte count divided by 4. A descriptor with a count of zero issues no remote cycle and no local write.
- R6: After the last word of a descriptor, the engine fetches the descriptor at the link address, unless the final flag is set. If it is set, the engine sets done and clears busy.
- R7: A go pulse while busy is ignored. The running chain completes unchanged, and the newly presented head address is never fetched.
- R8: A remote read not acknowledged within TIMEOUT cycles (default 16) is dropped after exactly TIMEOUT cycles of bus_req. The rest of the chain is abandoned, err is set, err_desc holds the failing descriptor's address, and busy clears.
- R9: irq is high whenever irq_en is high and done or err is set. done and err are cleared when a new go is accepted.
- R10: bus_req and mem_req are never high together, and an unacknowledged remote request keeps its address until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_addr | input | 32 | Address of the first descriptor, sampled on go |
| go | input | 1 | Start pulse |
| irq_en | input | 1 | Enables irq |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Chain completed normally |
| err | output | 1 | Chain abandoned on a remote timeout |
| err_desc | output | 32 | Address of the descriptor that failed |
| irq | output | 1 | Completion or error interrupt |
| mem_req | output | 1 | Local memory request |
| mem_we | output | 1 | Local request is a write |
| mem_addr | output | 32 | Local byte address |
| mem_wdata | output | 32 | Local write data |
| mem_ack | input | 1 | Local memory acknowledge |
| mem_rdata | input | 32 | Local read data, valid with mem_ack |
| bus_req | output | 1 | Remote read request |
| bus_addr | output | 32 | Remote byte address |
| bus_am | output | 6 | Remote cycle-type code |
| bus_ack | input | 1 | Remote acknowledge |
| bus_rdata | input | 32 | Remote read data, valid with bus_ack |

## Verification
Some properties are checked on every cycle:
- the two master ports never request at the same time;
- a pending remote request holds its address;
- no remote request stays unacknowledged for more than TIMEOUT cycles;
- a go pulse in the idle state always starts a run;
- completion and error each leave the engine idle.

Other behaviour can only be shown by the bench's scenarios:
- the order and addresses of the remote and local cycles;
- the data that lands in memory;
- the skipping of zero-length descriptors;
- that a go pulse while busy has no effect;
- which descriptor is recorded on a timeout, and that the rest of the chain is left untouched.

// File: rtl/chain_dma_master.sv
module chain_dma_master #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int AMW     = 6,
  parameter int CNTW    = 24,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] head_addr,
  input  logic          go,
  input  logic          irq_en,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] err_desc,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [AMW-1:0] bus_am,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int WB  = DW / 8;
  localparam int SH  = $clog2(WB);
  localparam int WLW = CNTW - SH;
  localparam int TW  = $clog2(TIMEOUT + 1);
  localparam int AMT = DW - 3;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RD, S_WR} st_t;

  st_t            st;
  logic [1:0]     idx;
  logic [AW-1:0]  cur_desc, src, dst, next_ptr, hop_addr;
  logic [AMW-1:0] am;
  logic           last_f;
  logic [WLW-1:0] words_left;
  logic [DW-1:0]  data;
  logic [TW-1:0]  tmr;

  assign busy      = st != S_IDLE;
  assign irq       = irq_en & (done | err);
  assign mem_req   = st == S_FETCH || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_addr  = (st == S_WR) ? dst : cur_desc + AW'(idx) * AW'(WB);
  assign mem_wdata = data;
  assign bus_req   = st == S_RD;
  assign bus_addr  = src;
  assign bus_am    = am;
  assign hop_addr  = (st == S_FETCH) ? AW'(mem_rdata) : next_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      cur_desc   <= '0;
      src        <= '0;
      dst        <= '0;
      next_ptr   <= '0;
      am         <= '0;
      last_f     <= 1'b0;
      words_left <= '0;
      data       <= '0;
      tmr        <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_desc   <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st       <= S_FETCH;
          idx      <= '0;
          cur_desc <= head_addr;
          done     <= 1'b0;
          err      <= 1'b0;
        end
        S_FETCH: if (mem_ack) begin
          idx <= idx + 2'd1;
          case (idx)
            2'd0: src <= AW'(mem_rdata);
            2'd1: dst <= AW'(mem_rdata);
            2'd2: begin
              last_f     <= mem_rdata[DW-1];
              am         <= mem_rdata[AMT -: AMW];
              words_left <= mem_rdata[CNTW-1:SH];
            end
            default: begin
              next_ptr <= AW'(mem_rdata);
              if (words_left != '0) begin
                st  <= S_RD;
                tmr <= '0;
              end else if (last_f) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                cur_desc <= hop_addr;
                idx      <= '0;
              end
            end
          endcase
        end
        S_RD: begin
          if (bus_ack) begin
            data <= bus_rdata;
            st   <= S_WR;
          end else if (tmr == TW'(TIMEOUT - 1)) begin
            st       <= S_IDLE;
            err      <= 1'b1;
            err_desc <= cur_desc;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_WR: if (mem_ack) begin
          src        <= src + AW'(WB);
          dst        <= dst + AW'(WB);
          words_left <= words_left - 1'b1;
          tmr        <= '0;
          if (words_left != WLW'(1)) begin
            st <= S_RD;
          end else if (last_f) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st       <= S_FETCH;
            idx      <= '0;
            cur_desc <= hop_addr;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_dma_master_chk.sv
module chain_dma_master_chk #(
  parameter int AW      = 32,
  parameter int TIMEOUT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_req,
  input logic          bus_req,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr
);
  localparam int CW = $clog2(TIMEOUT + 2);
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wait_cnt <= '0;
    else if (bus_req && !bus_ack) wait_cnt <= wait_cnt + 1'b1;
    else wait_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !mem_req));
  a_r2_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && mem_req));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !bus_req));
  a_r8_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (wait_cnt < CW'(TIMEOUT)));
  a_r8_hold_or_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req || err));
  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && mem_req));
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (!bus_req || $stable(bus_addr)));
endmodule

bind chain_dma_master chain_dma_master_chk #(.AW(AW), .TIMEOUT(TIMEOUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr)
);

// File: tb/chain_dma_master_tb_top.sv
module chain_dma_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam int NE = 4;
  // each entry: {src, byte count, am}
  localparam logic [31:0] T_SRC [NE] = '{32'h0001_0000, 32'h0002_0040, 32'h0003_0100, 32'h0004_0000};
  localparam int          T_LEN [NE] = '{12, 0, 8, 4};
  localparam logic [5:0]  T_AM  [NE] = '{6'h09, 6'h0D, 6'h39, 6'h0B};

  logic clk = 0, rst_n = 0, go = 0, irq_en = 0;
  logic [31:0] head_addr = 0;
  logic busy, done, err, irq, mem_req, mem_we, mem_ack, bus_req, bus_ack;
  logic [31:0] err_desc, mem_addr, mem_wdata, mem_rdata, bus_addr, bus_rdata;
  logic [5:0] bus_am;

  chain_dma_master dut_i (
    .clk(clk), .rst_n(rst_n), .head_addr(head_addr), .go(go), .irq_en(irq_en),
    .busy(busy), .done(done), .err(err), .err_desc(err_desc), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_am(bus_am),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [256];
  logic        tb_we = 0;
  logic [31:0] tb_wa = 0, tb_wd = 0;
  logic [31:0] log_addr [64];
  logic [5:0]  log_am [64];
  int          log_n = 0, miss_cycles = 0;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
    mem_ack = 0; bus_ack = 0; mem_rdata = 0; bus_rdata = 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
    end
    bus_ack <= bus_req && !bus_ack && bus_addr[31:28] != 4'hF;
    bus_rdata <= pat(bus_addr);
    if (bus_req && bus_ack) begin
      log_addr[log_n[5:0]] <= bus_addr;
      log_am[log_n[5:0]] <= bus_am;
      log_n <= log_n + 1;
    end
    if (bus_req && bus_addr[31:28] == 4'hF) miss_cycles <= miss_cycles + 1;
  end

  always @(posedge clk) if (cyc > 100000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic desc(input logic [31:0] at, input logic [31:0] s, input logic [31:0] d,
                      input int len, input logic [5:0] am, input bit last, input logic [31:0] nx);
    put(at, s); put(at + 4, d);
    put(at + 8, {last, 1'b0, am, 24'(len)});
    put(at + 12, nx);
  endtask

  task automatic start(input logic [31:0] h);
    @(negedge clk); head_addr = h; go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk(n < 3000, "R6 run ends", 32'(n), 32'd3000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !err && !irq, "R1 status at reset", {busy, done, err, irq}, 0);
    chk(!bus_req && !mem_req, "R1 no request at reset", {bus_req, mem_req}, 0);
    rst_n = 1;

    // table-driven chain: R3 R4 R5 R6
    for (int i = 0; i < NE; i++)
      desc(32'(i * 16), T_SRC[i], 32'h200 + 32'(i * 64), T_LEN[i], T_AM[i], i == NE - 1, 32'((i + 1) * 16));
    desc(32'h80, 32'h0007_0000, 32'h380, 4, 6'h09, 1'b1, 32'h0);
    irq_en = 1;
    @(negedge clk); head_addr = 32'h0; go = 1;
    @(negedge clk); go = 0;
    chk(busy && mem_req && !mem_we && mem_addr == 32'h0, "R2 fetch head", mem_addr, 32'h0);
    repeat (5) @(negedge clk);
    start(32'h80); // R7: ignored while busy
    wait_idle();
    chk(done && !err, "R6 done set", {done, err}, 32'h2);
    chk(irq, "R9 irq on done", irq, 1);
    begin
      int e = 0;
      for (int i = 0; i < NE; i++) begin
        for (int k = 0; k < T_LEN[i] / 4; k++) begin
          chk(mem[(32'h200 + i * 64 + k * 4) >> 2] == pat(T_SRC[i] + 32'(k * 4)), "R4 data placed",
              mem[(32'h200 + i * 64 + k * 4) >> 2], pat(T_SRC[i] + 32'(k * 4)));
          chk(log_addr[e] == T_SRC[i] + 32'(k * 4), "R4 source advance", log_addr[e], T_SRC[i] + 32'(k * 4));
          chk(log_am[e] == T_AM[i], "R3 cycle code", 32'(log_am[e]), 32'(T_AM[i]));
          e++;
        end
      end
      chk(log_n == e, "R5 remote cycle count", 32'(log_n), 32'(e));
    end
    chk(mem[32'h240 >> 2] == 32'hDEAD_BEEF, "R5 zero length no write", mem[32'h240 >> 2], 32'hDEAD_BEEF);
    chk(mem[32'h380 >> 2] == 32'hDEAD_BEEF, "R7 ignored go", mem[32'h380 >> 2], 32'hDEAD_BEEF);

    // R8: timeout aborts chain
    desc(32'h40, 32'h0005_0000, 32'h300, 8, 6'h09, 1'b0, 32'h50);
    desc(32'h50, 32'hF000_0000, 32'h340, 4, 6'h09, 1'b0, 32'h60);
    desc(32'h60, 32'h0006_0000, 32'h360, 4, 6'h09, 1'b1, 32'h0);
    start(32'h40);
    chk(!done && !err, "R9 flags cleared on go", {done, err}, 0);
    wait_idle();
    chk(err && !done, "R8 err set", {done, err}, 32'h1);
    chk(err_desc == 32'h50, "R8 failing descriptor", err_desc, 32'h50);
    chk(miss_cycles == TMO, "R8 request length", 32'(miss_cycles), 32'(TMO));
    chk(mem[32'h304 >> 2] == pat(32'h0005_0004), "R8 earlier words kept", mem[32'h304 >> 2], pat(32'h0005_0004));
    chk(mem[32'h340 >> 2] == 32'hDEAD_BEEF && mem[32'h360 >> 2] == 32'hDEAD_BEEF,
        "R8 rest abandoned", mem[32'h360 >> 2], 32'hDEAD_BEEF);
    chk(irq, "R9 irq on err", irq, 1);
    irq_en = 0;
    @(negedge clk);
    chk(!irq, "R9 irq masked", irq, 0);

    // restart after error
    start(32'h80);
    wait_idle();
    chk(done && !err, "R9 err cleared by new run", {done, err}, 32'h2);
    chk(mem[32'h380 >> 2] == pat(32'h0007_0000), "R6 single final descriptor",
        mem[32'h380 >> 2], pat(32'h0007_0000));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule